// File: doc/BRIEF.md
# Half-Bridge Adaptive Dead-Time Gate Sequencer

This block turns a decoded PWM level into the two gate enable commands of a synchronous buck half bridge. It does not use a fixed dead time. Before it turns on either switch, it waits for digitized feedback from the analog side. The high-side enable waits until the low-side gate voltage is reported low. The low-side enable waits until the switch node is reported low.

Two timed rules handle a switch node that never falls:

- **Dead-time timeout.** If the switch node stays high for too long after the high side turns off, the low side is forced on anyway, so the bootstrap stays charged.
- **Fault hold.** If the switch node then stays high for a long, continuous period, both gates are held off. They stay off until the next fresh rising PWM edge.

Two qualifiers sit in front of the sequencer:

- A supply qualifier with hysteresis, built from two comparator flags.
- A shutdown input that pulls both gates low at once.

Top module: `hbg_gate_seq`

## Requirements
- R1: While rst_n is low at a clock edge, hs_en, ls_en and fault_hold read 0 after that edge.
- R2: Both gates stay low until sup_rise_ok has been sampled high. Once enabled, the block stays enabled while sup_fall_ok stays high, even if sup_rise_ok returns low (hysteresis).
- R3: When sup_fall_ok and sup_rise_ok are both sampled low, both gates read 0 after that edge. They stay 0 until sup_rise_ok is sampled high again.
- R4: PWM high drops ls_en after the edge that samples it. hs_en rises only after an edge that samples lg_low high, and never earlier.
- R5: PWM low drops hs_en after the edge that samples it. ls_en rises after the edge that samples sw_low high.
- R6: After the high side turns off, if sw_low stays 0, ls_en is forced high once the wait has lasted DEAD_CYC cycles: low for DEAD_CYC edges, high after the next.
- R7: While the low side is forced on, sw_low sampled 0 for FAULT_CYC consecutive edges turns both gates off and sets fault_hold. Any cycle with sw_low high restarts that count.
- R8: In fault hold, both gates stay low whatever sw_low and lg_low do. Only a new rising PWM edge (sampled 1 after a sampled 0) leaves fault hold, and the R4 sequence then follows.
- R9: shdn high forces hs_en and ls_en to 0 in the same cycle, without waiting for a clock edge. After release, the sequence restarts from the all-off state.
- R10: hs_en and ls_en are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_hi | input | 1 | Decoded PWM level, 1 = high side requested |
| shdn | input | 1 | Shutdown from the PWM decoder; forces both gates off |
| sup_rise_ok | input | 1 | Supply above the rising threshold |
| sup_fall_ok | input | 1 | Supply above the falling threshold |
| lg_low | input | 1 | Low-side gate voltage below its release level |
| sw_low | input | 1 | Switch-node voltage below its release level |
| hs_en | output | 1 | High-side gate command |
| ls_en | output | 1 | Low-side gate command |
| fault_hold | output | 1 | High while the gates are latched off after a switch-node fault |

## Verification
The bench holds lg_low low after a rising PWM edge. A sequencer that used a fixed delay instead of this feedback would raise hs_en too early.

It lets the switch node stay high after a falling edge and checks that ls_en turns on exactly DEAD_CYC cycles later. An off-by-one in the timeout shows up there.

During the forced-on phase it inserts a single sw_low pulse. A fault counter that does not restart on that pulse would latch the fault early.

It also checks three more cases:
- That fault hold ignores feedback and leaves only on a fresh rising edge.
- That shutdown blanks the gates in the same cycle.
- That a drop in supply followed by only the falling-threshold flag returning keeps the gates off, as the hysteresis requires.

// File: rtl/hbg_pkg.sv
// Shared types for the half-bridge gate sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package hbg_pkg;

    typedef enum logic [2:0] {
        ST_OFF           = 3'd0,
        ST_LOW_ON        = 3'd1,
        ST_WAIT_LOW_FALL = 3'd2,
        ST_HIGH_ON       = 3'd3,
        ST_WAIT_PHASE    = 3'd4,
        ST_FAULT_HOLD    = 3'd5
    } seq_state_t;

endpackage

// File: rtl/hbg_supply_qual.sv
// Supply qualifier with hysteresis built from two comparator flags.
// The enable sets when the rising-threshold flag is seen and clears when the
// falling-threshold flag drops.
// Assumes: both flags are already synchronized to clk.
module hbg_supply_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_ok,
    input  logic fall_ok,
    output logic sup_on
);

    // Hold the enable between the two thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n)        sup_on <= 1'b0;
        else if (rise_ok)  sup_on <= 1'b1;
        else if (!fall_ok) sup_on <= 1'b0;
    end

endmodule

// File: rtl/hbg_pwm_edge.sv
// Rising-edge detector for the decoded PWM level.
// Assumes: pwm_hi is synchronous to clk. After reset the previous level is
// taken as low.
module hbg_pwm_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    output logic pwm_rise
);

    logic pwm_q;

    // Remember last cycle's PWM level.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_hi;
    end

    assign pwm_rise = pwm_hi & ~pwm_q;

endmodule

// File: rtl/hbg_dwell_timer.sv
// Counts consecutive cycles with run high.
// done is high in the LIMIT-th such cycle, so the edge that follows is the
// LIMIT-th consecutive edge with run sampled high.
// A cycle with run low clears the count.
// Assumes: LIMIT >= 1.
module hbg_dwell_timer #(
    parameter int LIMIT = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Saturating count of consecutive run cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run)         cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign done = run && (cnt == LAST);

endmodule

// File: rtl/hbg_gate_seq.sv
// Adaptive dead-time gate sequencer for a synchronous buck half bridge.
// Produces the high-side and low-side gate enables from a decoded PWM level:
// - each turn-on waits for feedback showing the opposite switch is off;
// - a timeout forces the low side on;
// - a persistence fault latches both gates off until a new rising PWM edge.
// Assumes: all inputs are synchronous to clk. DEAD_CYC and FAULT_CYC are
// cycle counts of the clk period (defaults suit 50 MHz).
module hbg_gate_seq
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC  = 13,
    parameter int FAULT_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic shdn,
    input  logic sup_rise_ok,
    input  logic sup_fall_ok,
    input  logic lg_low,
    input  logic sw_low,
    output logic hs_en,
    output logic ls_en,
    output logic fault_hold
);

    seq_state_t state, state_nxt;
    logic       forced, forced_nxt;
    logic       sup_on, pwm_rise, dead_done, fault_done;
    logic       enable, dead_run, fault_run;

    hbg_supply_qual u_sup (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_ok (sup_rise_ok),
        .fall_ok (sup_fall_ok),
        .sup_on  (sup_on)
    );

    hbg_pwm_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_hi   (pwm_hi),
        .pwm_rise (pwm_rise)
    );

    assign enable    = sup_on && !shdn;
    assign dead_run  = (state == ST_WAIT_PHASE);
    assign fault_run = (state == ST_LOW_ON) && forced && !sw_low && !pwm_hi;

    hbg_dwell_timer #(.LIMIT(DEAD_CYC)) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dead_run),
        .done  (dead_done)
    );

    hbg_dwell_timer #(.LIMIT(FAULT_CYC)) u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (fault_run),
        .done  (fault_done)
    );

    // Next-state and forced-flag decision.
    always_comb begin
        state_nxt  = state;
        forced_nxt = forced;
        if (!enable) begin
            state_nxt  = ST_OFF;
            forced_nxt = 1'b0;
        end else begin
            unique case (state)
                ST_OFF: begin
                    state_nxt = pwm_hi ? ST_WAIT_LOW_FALL : ST_WAIT_PHASE;
                end
                ST_LOW_ON: begin
                    if (pwm_hi) begin
                        state_nxt  = ST_WAIT_LOW_FALL;
                        forced_nxt = 1'b0;
                    end else if (fault_done) begin
                        state_nxt  = ST_FAULT_HOLD;
                        forced_nxt = 1'b0;
                    end
                end
                ST_WAIT_LOW_FALL: begin
                    if (!pwm_hi)     state_nxt = ST_WAIT_PHASE;
                    else if (lg_low) state_nxt = ST_HIGH_ON;
                end
                ST_HIGH_ON: begin
                    if (!pwm_hi) state_nxt = ST_WAIT_PHASE;
                end
                ST_WAIT_PHASE: begin
                    if (pwm_hi) begin
                        state_nxt = ST_WAIT_LOW_FALL;
                    end else if (sw_low) begin
                        state_nxt  = ST_LOW_ON;
                        forced_nxt = 1'b0;
                    end else if (dead_done) begin
                        state_nxt  = ST_LOW_ON;
                        forced_nxt = 1'b1;
                    end
                end
                ST_FAULT_HOLD: begin
                    if (pwm_rise) state_nxt = ST_WAIT_LOW_FALL;
                end
                default: begin
                    state_nxt  = ST_OFF;
                    forced_nxt = 1'b0;
                end
            endcase
        end
    end

    // State and forced-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_OFF;
            forced <= 1'b0;
        end else begin
            state  <= state_nxt;
            forced <= forced_nxt;
        end
    end

    // Gate commands: state decode blanked by supply and shutdown at once.
    assign hs_en      = (state == ST_HIGH_ON) && enable;
    assign ls_en      = (state == ST_LOW_ON)  && enable;
    assign fault_hold = (state == ST_FAULT_HOLD);

endmodule

// File: rtl/hbg_gate_seq_chk.sv
// Property checker for hbg_gate_seq, bound into every instance.
// Assumes: clocked on the sequencer's clock, disabled during reset.
module hbg_gate_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic pwm_hi,
    input logic shdn,
    input logic sup_rise_ok,
    input logic sup_fall_ok,
    input logic lg_low,
    input logic sw_low,
    input logic sup_on,
    input logic hs_en,
    input logic ls_en,
    input logic fault_hold
);

    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    a_r9_shutdown_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |-> (!hs_en && !ls_en));

    a_r3_supply_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (!sup_fall_ok && !sup_rise_ok) |=> (!hs_en && !ls_en));

    a_r2_gated_until_on: assert property (@(posedge clk) disable iff (!rst_n)
        !sup_on |-> (!hs_en && !ls_en));

    a_r4_high_needs_feedback: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(lg_low));

    a_r5_low_after_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> !$past(hs_en));

    a_r7_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hold |-> (!hs_en && !ls_en));

    a_r8_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_hold) |-> ($past(pwm_hi) || $past(shdn) || !$past(sup_on)));

endmodule

bind hbg_gate_seq hbg_gate_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_hi      (pwm_hi),
    .shdn        (shdn),
    .sup_rise_ok (sup_rise_ok),
    .sup_fall_ok (sup_fall_ok),
    .lg_low      (lg_low),
    .sw_low      (sw_low),
    .sup_on      (sup_on),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .fault_hold  (fault_hold)
);

// File: tb/test_hbg_gate_seq.sv
// Scoreboard bench for hbg_gate_seq.
// The driver queues expected outputs stamped with a sample index.
// The monitor samples 5 ns after each rising edge and compares.
module test_hbg_gate_seq;

    localparam int DEAD  = 13;
    localparam int FAULT = 100;

    logic clk = 1'b0;
    logic rst_n, pwm_hi, shdn, sup_rise_ok, sup_fall_ok, lg_low, sw_low;
    logic hs_en, ls_en, fault_hold;

    typedef struct {
        int    at;
        bit    hs;
        bit    ls;
        bit    fh;
        string req;
    } exp_t;

    exp_t sb[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    hbg_gate_seq #(.DEAD_CYC(DEAD), .FAULT_CYC(FAULT)) i_hbg_gate_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwm_hi      (pwm_hi),
        .shdn        (shdn),
        .sup_rise_ok (sup_rise_ok),
        .sup_fall_ok (sup_fall_ok),
        .lg_low      (lg_low),
        .sw_low      (sw_low),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .fault_hold  (fault_hold)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int k, input bit hs, input bit ls, input bit fh, input string req);
        exp_t e;
        e.at = cyc + k; e.hs = hs; e.ls = ls; e.fh = fh; e.req = req;
        sb.push_back(e);
    endtask

    task automatic check_now(input bit hs, input bit ls, input string req);
        n_chk++;
        if (hs_en !== hs || ls_en !== ls) begin
            n_fail++;
            $display("FAIL %s: hs/ls=%b%b expected %b%b", req, hs_en, ls_en, hs, ls);
        end
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: sample after each edge, check overlap, pop due items.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            cyc++;
            n_chk++;
            if (hs_en === 1'b1 && ls_en === 1'b1) begin
                n_fail++;
                $display("FAIL R10: hs/ls=11 expected not both high at sample %0d", cyc);
            end
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (e.at < cyc) begin
                    n_fail++;
                    $display("FAIL %s: item for sample %0d missed (now %0d)", e.req, e.at, cyc);
                end else if (hs_en !== e.hs || ls_en !== e.ls || fault_hold !== e.fh) begin
                    n_fail++;
                    $display("FAIL %s: sample %0d hs/ls/fh=%b%b%b expected %b%b%b",
                             e.req, cyc, hs_en, ls_en, fault_hold, e.hs, e.ls, e.fh);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        summary();
    end

    // Driver.
    initial begin
        rst_n = 1'b0; pwm_hi = 1'b0; shdn = 1'b0;
        sup_rise_ok = 1'b0; sup_fall_ok = 1'b0; lg_low = 1'b1; sw_low = 1'b1;
        tick(3);
        expect_at(1, 0, 0, 0, "R1");
        rst_n = 1'b1;
        tick(1);

        // R2: only the falling flag present, so the gates stay off.
        sup_fall_ok = 1'b1;
        for (int i = 1; i <= 4; i++) expect_at(i, 0, 0, 0, "R2");
        tick(4);
        // R2: rising flag enables; OFF -> WAIT_PHASE -> LOW_ON.
        sup_rise_ok = 1'b1;
        expect_at(2, 0, 0, 0, "R2");
        expect_at(3, 0, 1, 0, "R2");
        tick(3);
        // R2: hysteresis keeps the block on without the rising flag.
        sup_rise_ok = 1'b0;
        expect_at(3, 0, 1, 0, "R2");
        tick(3);

        // R4: rising PWM with the low-gate feedback still high.
        pwm_hi = 1'b1; lg_low = 1'b0;
        expect_at(1, 0, 0, 0, "R4");
        expect_at(3, 0, 0, 0, "R4");
        tick(3);
        lg_low = 1'b1;
        expect_at(1, 1, 0, 0, "R4");
        tick(2);

        // R5: falling PWM, switch node falls after a few cycles.
        pwm_hi = 1'b0; sw_low = 1'b0;
        expect_at(1, 0, 0, 0, "R5");
        tick(3);
        sw_low = 1'b1;
        expect_at(1, 0, 1, 0, "R5");
        tick(2);

        // Back to high side for the timeout case.
        pwm_hi = 1'b1;
        expect_at(2, 1, 0, 0, "R4");
        tick(2);

        // R6: switch node never falls, so a forced low side after DEAD cycles.
        pwm_hi = 1'b0; sw_low = 1'b0;
        expect_at(DEAD, 0, 0, 0, "R6");
        expect_at(DEAD + 1, 0, 1, 0, "R6");
        tick(DEAD + 1);

        // R7: run partway, one sw_low pulse restarts the count.
        tick(30);
        sw_low = 1'b1;
        expect_at(1, 0, 1, 0, "R7");
        tick(1);
        sw_low = 1'b0;
        expect_at(FAULT - 1, 0, 1, 0, "R7");
        expect_at(FAULT, 0, 0, 1, "R7");
        tick(FAULT);

        // R8: feedback changes do not release the hold.
        sw_low = 1'b1; lg_low = 1'b0;
        expect_at(2, 0, 0, 1, "R8");
        tick(2);
        lg_low = 1'b1; pwm_hi = 1'b1;
        expect_at(1, 0, 0, 0, "R8");
        expect_at(2, 1, 0, 0, "R8");
        tick(2);

        // R9: shutdown blanks the gates at once, then the sequence restarts.
        shdn = 1'b1;
        #1;
        check_now(0, 0, "R9");
        expect_at(1, 0, 0, 0, "R9");
        tick(2);
        shdn = 1'b0;
        expect_at(1, 0, 0, 0, "R9");
        expect_at(2, 1, 0, 0, "R9");
        tick(2);

        // R3: supply drop, partial recovery keeps the gates off, full recovery enables.
        sup_fall_ok = 1'b0;
        expect_at(1, 0, 0, 0, "R3");
        tick(2);
        sup_fall_ok = 1'b1;
        expect_at(3, 0, 0, 0, "R3");
        tick(3);
        sup_rise_ok = 1'b1;
        expect_at(3, 1, 0, 0, "R3");
        tick(4);

        while (sb.size() > 0) tick(1);
        tick(1);
        summary();
    end

endmodule